// File: doc/BRIEF.md
# Partitionable Associative Memory

This block is a 16-entry content-addressable memory of 64-bit words. Every entry carries a two-bit validity code beside its data. A compare runs continuously against a comparand register. Bits can be left out of the compare through a mask register and through a run-time split of each word into a compared field and an uncompared field. The uncompared field holds data tied to the compared content of the same entry. It is written and read like ordinary storage.

Commands arrive on a valid/ready channel. A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. Commands load the internal registers, write, read and invalidate entries, and move words between the array and the comparand or mask registers. Array accesses take their address from the command, from an internal address register, from the lowest empty entry or from the highest-priority match.

Read data leaves on a second valid/ready channel. A read result stays on `rd_data` with `rd_valid` high until the consumer takes it with `rd_ready`. While a result is waiting and `rd_ready` is low, `cmd_ready` is low, so no command is lost or reordered behind a stalled read. The match flag, match address, free address and full flag are plain status outputs.

Top module: `assoc_mem`

## Requirements
- R1: After reset, every entry is empty, and `match_flag`, `full_flag` and `rd_valid` are low. `free_addr` is 0 and `cmd_ready` is high.
- R2: A write command stores the data and sets the entry's validity code to 11. `free_addr` then shows the lowest-numbered entry whose code is 00. `full_flag` rises when no entry is empty.
- R3: The invalidate command (op 12) sets the addressed entry's code to 00. The entry then takes part in `free_addr` and `full_flag` again, and it can no longer match.
- R4: `match_addr` is the lowest-numbered valid entry whose compared bits equal the comparand. `match_flag` shows that such an entry exists. A bit set to 1 in mask register 1 is left out of the compare. These outputs, together with `free_addr` and `full_flag`, are registered, and they reflect the state one clock after any change.
- R5: Bits 8:6 of the control register set the split. Bits 7:6 give the number of 16-bit uncompared segments (0 to 3). Bit 8 places them at the most-significant end (1) or the least-significant end (0). For example, 001 leaves the upper 48 bits compared. Uncompared bits never affect a match.
- R6: A read (op 7) returns the whole stored word, both fields, on `rd_data` one clock after acceptance, with `rd_valid` high.
- R7: `cmd_asrc` selects the access address: 0 is `cmd_addr`, 1 is the address register, 2 is `free_addr` and 3 is `match_addr`.
- R8: `cmd_msel` selects a write mask: 0 or 3 is none, 1 is mask register 1 and 2 is mask register 2. Word bits where the selected mask holds 1 keep their old value.
- R9: Op 8 writes the comparand into an entry under the selected mask and makes the entry valid. Op 9 loads the comparand from an entry. Ops 10 and 11 load mask register 1 or mask register 2 from an entry.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold and `cmd_ready` is low. A command presented during this time is not accepted.

Op codes: 0 none, 1 load comparand, 2 load mask 1, 3 load mask 2, 4 load address register (low bits of `cmd_data`), 5 load control register (low 16 bits), 6 write, 7 read, 8 comparand to array, 9 array to comparand, 10 array to mask 1, 11 array to mask 2, 12 invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 4 | Operation code |
| cmd_asrc | input | 2 | Address source select |
| cmd_msel | input | 2 | Write mask select |
| cmd_addr | input | 4 | Explicit entry address |
| cmd_data | input | 64 | Write or register-load data |
| rd_valid | output | 1 | Read result present |
| rd_ready | input | 1 | Read result taken |
| rd_data | output | 64 | Read result word |
| match_flag | output | 1 | Some valid entry matches |
| match_addr | output | 4 | Highest-priority matching entry |
| free_addr | output | 4 | Lowest empty entry |
| full_flag | output | 1 | No entry is empty |

## Verification
The hardest case to reach is a command that takes its address from the match or free pointer when that pointer has to be a specific entry. Getting there needs a particular history of fills, invalidations and comparand loads. The bench builds that history with directed sequences. It first fills the array through the free pointer, then plants a duplicate word above its original and invalidates the lower copy. Only after that does it issue writes addressed through the match pointer and the free pointer. A reference model in the bench tracks every register and entry, so that each status output can be predicted after each command.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
  typedef enum logic [3:0] {
    OP_NOP         = 4'd0,
    OP_LD_CMP      = 4'd1,
    OP_LD_MSK1     = 4'd2,
    OP_LD_MSK2     = 4'd3,
    OP_LD_ADDR     = 4'd4,
    OP_LD_CTRL     = 4'd5,
    OP_WRITE       = 4'd6,
    OP_READ        = 4'd7,
    OP_CMP_TO_ARR  = 4'd8,
    OP_ARR_TO_CMP  = 4'd9,
    OP_ARR_TO_MSK1 = 4'd10,
    OP_ARR_TO_MSK2 = 4'd11,
    OP_INVALIDATE  = 4'd12
  } op_e;

  localparam logic [1:0] VCODE_EMPTY = 2'b00;
  localparam logic [1:0] VCODE_VALID = 2'b11;

  localparam logic [1:0] ASRC_PORT  = 2'd0;
  localparam logic [1:0] ASRC_AREG  = 2'd1;
  localparam logic [1:0] ASRC_FREE  = 2'd2;
  localparam logic [1:0] ASRC_MATCH = 2'd3;

  localparam int CTRL_W   = 16;
  localparam int PART_LSB = 6;
endpackage

// File: rtl/assoc_prio.sv
module assoc_prio #(
  parameter int N = 16,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [AW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = AW'(i);
    end
  end
endmodule

// File: rtl/assoc_fieldmask.sv
module assoc_fieldmask #(
  parameter int WIDTH = 64,
  parameter int SEG   = 16,
  localparam int NSEG = WIDTH / SEG
) (
  input  logic [2:0]       part,
  output logic [WIDTH-1:0] cmp_en
);
  int cnt;
  assign cnt = int'(part[1:0]);

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic is_ram;
    always_comb is_ram = part[2] ? (s >= NSEG - cnt) : (s < cnt);
    assign cmp_en[s*SEG +: SEG] = {SEG{~is_ram}};
  end
endmodule

// File: rtl/assoc_match.sv
module assoc_match #(
  parameter int WIDTH = 64,
  parameter int WORDS = 16
) (
  input  logic [WORDS-1:0][WIDTH-1:0] words,
  input  logic [WORDS-1:0]            live,
  input  logic [WIDTH-1:0]            key,
  input  logic [WIDTH-1:0]            care,
  output logic [WORDS-1:0]            hits
);
  for (genvar e = 0; e < WORDS; e++) begin : g_ent
    assign hits[e] = live[e] && (((words[e] ^ key) & care) == '0);
  end
endmodule

// File: rtl/assoc_mem.sv
module assoc_mem #(
  parameter int WORDS = 16,
  parameter int WIDTH = 64,
  parameter int SEG   = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [3:0]       cmd_op,
  input  logic [1:0]       cmd_asrc,
  input  logic [1:0]       cmd_msel,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [WIDTH-1:0] cmd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  output logic             match_flag,
  output logic [AW-1:0]    match_addr,
  output logic [AW-1:0]    free_addr,
  output logic             full_flag
);
  import assoc_pkg::*;

  logic [WORDS-1:0][WIDTH-1:0] mem;
  logic [WORDS-1:0][1:0]       vcode;
  logic [WIDTH-1:0]            cmp_q, msk1_q, msk2_q;
  logic [AW-1:0]               addr_q;
  logic [CTRL_W-1:0]           ctrl_q;

  logic [WORDS-1:0] live, empty, hits;
  logic [WIDTH-1:0] field_en, care;
  logic             hit_any, free_any;
  logic [AW-1:0]    hit_idx, free_idx;

  for (genvar i = 0; i < WORDS; i++) begin : g_vc
    assign live[i]  = (vcode[i] == VCODE_VALID);
    assign empty[i] = (vcode[i] == VCODE_EMPTY);
  end

  assoc_fieldmask #(.WIDTH(WIDTH), .SEG(SEG)) u_field (
    .part   (ctrl_q[PART_LSB+2:PART_LSB]),
    .cmp_en (field_en)
  );

  assign care = field_en & ~msk1_q;

  assoc_match #(.WIDTH(WIDTH), .WORDS(WORDS)) u_match (
    .words (mem),
    .live  (live),
    .key   (cmp_q),
    .care  (care),
    .hits  (hits)
  );

  assoc_prio #(.N(WORDS)) u_hit_prio (
    .req (hits),
    .any (hit_any),
    .idx (hit_idx)
  );

  assoc_prio #(.N(WORDS)) u_free_prio (
    .req (empty),
    .any (free_any),
    .idx (free_idx)
  );

  op_e              op;
  logic             acc;
  logic [AW-1:0]    eaddr;
  logic [WIDTH-1:0] wmask, wsrc, merged;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = !rd_valid || rd_ready;
  assign acc       = cmd_valid && cmd_ready;

  always_comb begin
    unique case (cmd_asrc)
      ASRC_PORT:  eaddr = cmd_addr;
      ASRC_AREG:  eaddr = addr_q;
      ASRC_FREE:  eaddr = free_addr;
      default:    eaddr = match_addr;
    endcase
  end

  always_comb begin
    unique case (cmd_msel)
      2'd1:    wmask = msk1_q;
      2'd2:    wmask = msk2_q;
      default: wmask = '0;
    endcase
  end

  assign wsrc   = (op == OP_CMP_TO_ARR) ? cmp_q : cmd_data;
  assign merged = (mem[eaddr] & wmask) | (wsrc & ~wmask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem    <= '0;
      vcode  <= '0;
      cmp_q  <= '0;
      msk1_q <= '0;
      msk2_q <= '0;
      addr_q <= '0;
      ctrl_q <= '0;
    end else if (acc) begin
      unique case (op)
        OP_LD_CMP:      cmp_q  <= cmd_data;
        OP_LD_MSK1:     msk1_q <= cmd_data;
        OP_LD_MSK2:     msk2_q <= cmd_data;
        OP_LD_ADDR:     addr_q <= cmd_data[AW-1:0];
        OP_LD_CTRL:     ctrl_q <= cmd_data[CTRL_W-1:0];
        OP_WRITE, OP_CMP_TO_ARR: begin
          mem[eaddr]   <= merged;
          vcode[eaddr] <= VCODE_VALID;
        end
        OP_ARR_TO_CMP:  cmp_q  <= mem[eaddr];
        OP_ARR_TO_MSK1: msk1_q <= mem[eaddr];
        OP_ARR_TO_MSK2: msk2_q <= mem[eaddr];
        OP_INVALIDATE:  vcode[eaddr] <= VCODE_EMPTY;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (acc && op == OP_READ) begin
      rd_valid <= 1'b1;
      rd_data  <= mem[eaddr];
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_flag <= 1'b0;
      match_addr <= '0;
      free_addr  <= '0;
      full_flag  <= 1'b0;
    end else begin
      match_flag <= hit_any;
      match_addr <= hit_idx;
      free_addr  <= free_idx;
      full_flag  <= !free_any;
    end
  end
endmodule

// File: rtl/assoc_mem_sva.sv
module assoc_mem_sva #(
  parameter int WORDS = 16,
  parameter int WIDTH = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [3:0]       cmd_op,
  input logic [1:0]       cmd_asrc,
  input logic [AW-1:0]    cmd_addr,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [WIDTH-1:0] rd_data,
  input logic             match_flag,
  input logic [AW-1:0]    free_addr,
  input logic             full_flag
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  // R1: state coming out of reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rd_valid && !match_flag && !full_flag && free_addr == '0));

  // R10: a stalled read result holds
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R10: commands blocked while a read result waits
  assert_cmd_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |-> !cmd_ready);

  // R2: a directly written entry is no longer reported as free
  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 4'd6 && cmd_asrc == 2'd0) ##1 !acc
      |=> (full_flag || free_addr != $past(cmd_addr, 2)));

  // R3: an invalidated entry becomes a free candidate
  assert_invalidate_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 4'd12 && cmd_asrc == 2'd0) ##1 !acc
      |=> (!full_flag && free_addr <= $past(cmd_addr, 2)));
endmodule

bind assoc_mem assoc_mem_sva #(.WORDS(WORDS), .WIDTH(WIDTH)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .cmd_asrc   (cmd_asrc),
  .cmd_addr   (cmd_addr),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .match_flag (match_flag),
  .free_addr  (free_addr),
  .full_flag  (full_flag)
);

// File: tb/assoc_mem_test.sv
`timescale 1ns/1ps
module assoc_mem_test;
  import assoc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [1:0]  cmd_asrc = '0;
  logic [1:0]  cmd_msel = '0;
  logic [3:0]  cmd_addr = '0;
  logic [63:0] cmd_data = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [63:0] rd_data;
  logic        match_flag;
  logic [3:0]  match_addr;
  logic [3:0]  free_addr;
  logic        full_flag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assoc_mem uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_asrc(cmd_asrc), .cmd_msel(cmd_msel), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .match_flag(match_flag), .match_addr(match_addr),
    .free_addr(free_addr), .full_flag(full_flag)
  );

  // reference model
  logic [63:0] m_mem [16];
  bit          m_vld [16];
  logic [63:0] m_cmp, m_m1, m_m2;
  logic [3:0]  m_areg;
  logic [15:0] m_ctrl;

  function automatic logic [63:0] ram_bits(input logic [15:0] c);
    logic [63:0] r = '0;
    int n = int'(c[7:6]);
    for (int s = 0; s < 4; s++) begin
      if (c[8] ? (s >= 4 - n) : (s < n)) r[s*16 +: 16] = 16'hFFFF;
    end
    return r;
  endfunction

  function automatic bit exp_mflag();
    logic [63:0] care = ~ram_bits(m_ctrl) & ~m_m1;
    for (int i = 0; i < 16; i++)
      if (m_vld[i] && (((m_mem[i] ^ m_cmp) & care) == 0)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [3:0] exp_maddr();
    logic [63:0] care = ~ram_bits(m_ctrl) & ~m_m1;
    for (int i = 0; i < 16; i++)
      if (m_vld[i] && (((m_mem[i] ^ m_cmp) & care) == 0)) return 4'(i);
    return 4'd0;
  endfunction

  function automatic logic [3:0] exp_free();
    for (int i = 0; i < 16; i++) if (!m_vld[i]) return 4'(i);
    return 4'd0;
  endfunction

  function automatic bit exp_full();
    for (int i = 0; i < 16; i++) if (!m_vld[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_status(input string req);
    chk({req, " match_flag"}, 64'(match_flag), 64'(exp_mflag()));
    chk({req, " match_addr"}, 64'(match_addr), 64'(exp_maddr()));
    chk({req, " free_addr"},  64'(free_addr),  64'(exp_free()));
    chk({req, " full_flag"},  64'(full_flag),  64'(exp_full()));
  endtask

  task automatic do_cmd(input string req, input op_e op, input logic [1:0] asrc,
                        input logic [1:0] msel, input logic [3:0] addr,
                        input logic [63:0] data);
    logic [3:0]  a;
    logic [63:0] m, rexp;
    a = (asrc == 2'd0) ? addr : (asrc == 2'd1) ? m_areg :
        (asrc == 2'd2) ? exp_free() : exp_maddr();
    m = (msel == 2'd1) ? m_m1 : (msel == 2'd2) ? m_m2 : 64'd0;
    rexp = m_mem[a];
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_asrc = asrc; cmd_msel = msel;
    cmd_addr = addr; cmd_data = data;
    @(posedge clk);
    case (op)
      OP_LD_CMP:      m_cmp = data;
      OP_LD_MSK1:     m_m1 = data;
      OP_LD_MSK2:     m_m2 = data;
      OP_LD_ADDR:     m_areg = data[3:0];
      OP_LD_CTRL:     m_ctrl = data[15:0];
      OP_WRITE:       begin m_mem[a] = (m_mem[a] & m) | (data & ~m); m_vld[a] = 1; end
      OP_CMP_TO_ARR:  begin m_mem[a] = (m_mem[a] & m) | (m_cmp & ~m); m_vld[a] = 1; end
      OP_ARR_TO_CMP:  m_cmp = m_mem[a];
      OP_ARR_TO_MSK1: m_m1 = m_mem[a];
      OP_ARR_TO_MSK2: m_m2 = m_mem[a];
      OP_INVALIDATE:  m_vld[a] = 0;
      default: ;
    endcase
    @(negedge clk);
    if (op == OP_READ) begin
      chk({req, " rd_valid"}, 64'(rd_valid), 64'd1);
      chk({req, " rd_data"}, rd_data, rexp);
    end
    cmd_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_status(req);
  endtask

  task automatic t_reset();
    chk("R1 match_flag", 64'(match_flag), 64'd0);
    chk("R1 full_flag", 64'(full_flag), 64'd0);
    chk("R1 free_addr", 64'(free_addr), 64'd0);
    chk("R1 rd_valid", 64'(rd_valid), 64'd0);
    chk("R1 cmd_ready", 64'(cmd_ready), 64'd1);
  endtask

  task automatic t_write_read();
    do_cmd("R2", OP_WRITE, 2'd0, 2'd0, 4'd0, 64'h1111_2222_3333_4444);
    chk("R2 free after first write", 64'(free_addr), 64'd1);
    do_cmd("R6", OP_READ, 2'd0, 2'd0, 4'd0, 64'd0);
  endtask

  task automatic t_fill();
    for (int i = 1; i < 16; i++)
      do_cmd("R7 free source", OP_WRITE, 2'd2, 2'd0, 4'd0,
             64'h0F0F_0000_0000_0000 + 64'(i) * 64'h0001_0001_0001_0001);
    chk("R2 full", 64'(full_flag), 64'd1);
    do_cmd("R6", OP_READ, 2'd0, 2'd0, 4'd9, 64'd0);
  endtask

  task automatic t_match();
    do_cmd("R4", OP_LD_CMP, 2'd0, 2'd0, 4'd0, m_mem[5]);
    chk("R4 single", 64'(match_addr), 64'd5);
    do_cmd("R4", OP_WRITE, 2'd0, 2'd0, 4'd12, m_mem[3]);
    do_cmd("R4", OP_LD_CMP, 2'd0, 2'd0, 4'd0, m_mem[3]);
    chk("R4 lowest wins", 64'(match_addr), 64'd3);
    do_cmd("R4", OP_LD_MSK1, 2'd0, 2'd0, 4'd0, 64'hFFFF);
    do_cmd("R4", OP_LD_CMP, 2'd0, 2'd0, 4'd0, m_mem[7] ^ 64'h00FF);
    chk("R4 masked bits ignored", 64'(match_addr), 64'd7);
    do_cmd("R4", OP_LD_CMP, 2'd0, 2'd0, 4'd0, m_mem[7] ^ 64'h1_0000);
    chk("R4 no match", 64'(match_flag), 64'd0);
    do_cmd("R4", OP_LD_MSK1, 2'd0, 2'd0, 4'd0, 64'd0);
  endtask

  task automatic t_partition();
    do_cmd("R5", OP_LD_CMP, 2'd0, 2'd0, 4'd0, m_mem[7] ^ 64'hFFFF);
    chk("R5 all compared", 64'(match_flag), 64'd0);
    do_cmd("R5", OP_LD_CTRL, 2'd0, 2'd0, 4'd0, 64'h0040);
    chk("R5 low field uncompared", 64'(match_addr), 64'd7);
    do_cmd("R5", OP_LD_CMP, 2'd0, 2'd0, 4'd0, m_mem[7] ^ 64'hFFFF_0000_0000_0000);
    chk("R5 upper still compared", 64'(match_flag), 64'd0);
    do_cmd("R5", OP_LD_CTRL, 2'd0, 2'd0, 4'd0, 64'h0140);
    chk("R5 high field uncompared", 64'(match_addr), 64'd7);
    do_cmd("R5", OP_LD_CTRL, 2'd0, 2'd0, 4'd0, 64'h01C0);
    do_cmd("R5", OP_LD_CTRL, 2'd0, 2'd0, 4'd0, 64'h0000);
  endtask

  task automatic t_invalidate();
    logic [63:0] w3 = m_mem[3];
    do_cmd("R3", OP_INVALIDATE, 2'd0, 2'd0, 4'd3, 64'd0);
    chk("R3 free", 64'(free_addr), 64'd3);
    chk("R3 not full", 64'(full_flag), 64'd0);
    do_cmd("R3", OP_LD_CMP, 2'd0, 2'd0, 4'd0, w3);
    chk("R3 empty entry skipped", 64'(match_addr), 64'd12);
  endtask

  task automatic t_addrsrc();
    do_cmd("R7", OP_LD_ADDR, 2'd0, 2'd0, 4'd0, 64'd9);
    do_cmd("R7 areg", OP_WRITE, 2'd1, 2'd0, 4'd0, 64'hDEAD_0009_BEEF_0009);
    do_cmd("R7 areg read", OP_READ, 2'd0, 2'd0, 4'd9, 64'd0);
    chk("R7 areg write", rd_data, 64'hDEAD_0009_BEEF_0009);
    do_cmd("R7 match", OP_WRITE, 2'd3, 2'd0, 4'd0, 64'hCAFE_0012_CAFE_0012);
    do_cmd("R7 match read", OP_READ, 2'd0, 2'd0, 4'd12, 64'd0);
    do_cmd("R7 free", OP_WRITE, 2'd2, 2'd0, 4'd0, 64'h3333_0003_3333_0003);
    do_cmd("R7 free read", OP_READ, 2'd0, 2'd0, 4'd3, 64'd0);
    do_cmd("R7 areg read", OP_READ, 2'd1, 2'd0, 4'd0, 64'd0);
  endtask

  task automatic t_masked();
    logic [63:0] o4 = m_mem[4];
    do_cmd("R8", OP_LD_MSK2, 2'd0, 2'd0, 4'd0, 64'h0000_0000_FFFF_FFFF);
    do_cmd("R8", OP_LD_MSK1, 2'd0, 2'd0, 4'd0, 64'hFFFF_FFFF_0000_0000);
    do_cmd("R8 mask2", OP_WRITE, 2'd0, 2'd2, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF);
    do_cmd("R8 mask2 read", OP_READ, 2'd0, 2'd0, 4'd4, 64'd0);
    chk("R8 mask2 keeps low", rd_data, {32'hFFFF_FFFF, o4[31:0]});
    do_cmd("R8 mask1", OP_WRITE, 2'd0, 2'd1, 4'd5, 64'd0);
    do_cmd("R8 mask1 read", OP_READ, 2'd0, 2'd0, 4'd5, 64'd0);
    do_cmd("R8 none", OP_WRITE, 2'd0, 2'd3, 4'd6, 64'h6666_6666_6666_6666);
    do_cmd("R8 none read", OP_READ, 2'd0, 2'd0, 4'd6, 64'd0);
    do_cmd("R8", OP_LD_MSK1, 2'd0, 2'd0, 4'd0, 64'd0);
  endtask

  task automatic t_moves();
    do_cmd("R9 to cmp", OP_ARR_TO_CMP, 2'd0, 2'd0, 4'd10, 64'd0);
    chk("R9 cmp loaded", 64'(match_addr), 64'(exp_maddr()));
    chk("R9 cmp flag", 64'(match_flag), 64'd1);
    do_cmd("R9", OP_LD_MSK2, 2'd0, 2'd0, 4'd0, 64'hFFFF_0000_0000_0000);
    do_cmd("R9 cmp to arr", OP_CMP_TO_ARR, 2'd0, 2'd2, 4'd2, 64'd0);
    do_cmd("R9 cmp to arr read", OP_READ, 2'd0, 2'd0, 4'd2, 64'd0);
    do_cmd("R9 to mask1", OP_ARR_TO_MSK1, 2'd0, 2'd0, 4'd11, 64'd0);
    do_cmd("R9 use mask1", OP_WRITE, 2'd0, 2'd1, 4'd13, 64'hFFFF_FFFF_FFFF_FFFF);
    do_cmd("R9 use mask1 read", OP_READ, 2'd0, 2'd0, 4'd13, 64'd0);
    do_cmd("R9 to mask2", OP_ARR_TO_MSK2, 2'd0, 2'd0, 4'd0, 64'd0);
    do_cmd("R9 use mask2", OP_WRITE, 2'd0, 2'd2, 4'd14, 64'd0);
    do_cmd("R9 use mask2 read", OP_READ, 2'd0, 2'd0, 4'd14, 64'd0);
    do_cmd("R9", OP_LD_MSK1, 2'd0, 2'd0, 4'd0, 64'd0);
  endtask

  task automatic t_backpressure();
    logic [63:0] exp8 = m_mem[8];
    rd_ready = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = OP_READ; cmd_asrc = 2'd0; cmd_addr = 4'd8;
    @(posedge clk);
    @(negedge clk);
    chk("R10 rd_valid", 64'(rd_valid), 64'd1);
    chk("R10 rd_data", rd_data, exp8);
    chk("R10 cmd_ready low", 64'(cmd_ready), 64'd0);
    cmd_op = OP_LD_CMP; cmd_data = 64'h0BAD_0BAD_0BAD_0BAD;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 held valid", 64'(rd_valid), 64'd1);
    chk("R10 held data", rd_data, exp8);
    cmd_valid = 1'b0;
    rd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 released", 64'(rd_valid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    check_status("R10 blocked command ignored");
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_mem[i] = '0; m_vld[i] = 0; end
    m_cmp = '0; m_m1 = '0; m_m2 = '0; m_areg = '0; m_ctrl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    t_reset();
    t_write_read();
    t_fill();
    t_match();
    t_partition();
    t_invalidate();
    t_addrsrc();
    t_masked();
    t_moves();
    t_backpressure();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end
endmodule